// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every 32-bit address presented to it, whether the access falls inside one of eight programmable protection regions and whether that access is allowed. Each region has a start address, a size code, a valid flag, two alternative attribute sets (A and B) and a 16-bit subregion mask. The attribute sets hold an access-permission code, a cacheable bit and a bufferable bit. Each region is cut into sixteen equal slices. The mask bit for the slice that the address lands in selects set B when it is 1 and set A when it is 0.

Configuration is loaded through a simple write port: a strobe, a 5-bit register selector and a 32-bit data word. Lookups need no handshake. The address, access kind and privilege sampled on a rising clock edge produce hit, miss, violation, region index, cacheable and bufferable on the outputs right after that edge. A lookup uses the configuration as it stood before that edge.

Top module: `mpu_region_lookup`

## Requirements
- R1: While reset is low and after it is released, every output is 0, protection is disabled and every region is invalid.
- R2: A write with `cfg_we` high is captured on the rising edge. The selector codes are: 0..7 region word for region n (bits 31:12 start address, bits 5:1 size code, bit 0 valid); 8 control (bit 0 enable); 9 and 10 permission codes for set A and set B (region n in bits 4n+3:4n); 11 and 12 cacheable bits for set A and set B; 13 and 14 bufferable bits for set A and set B (region n at bit n); 16..23 subregion mask for region n in bits 15:0.
- R3: While the enable bit is 0, every output is 0 for any address.
- R4: A region takes part in matching only if its valid bit is 1 and its size code is 11 or more.
- R5: A region with size code s covers 2^(s+1) bytes starting at its start address. An address hits when its bits 31:s+1 equal those of the start address. Size code 31 covers the whole address space.
- R6: When several regions hit, the lowest-numbered one is reported on `out_region` and supplies the attributes.
- R7: With protection enabled and no region hit, `out_miss` is 1 and every other output is 0. With a hit, `out_hit` is 1 and `out_miss` is 0.
- R8: The subregion index is address bits s:s-3. The mask bit at that index set to 1 selects attribute set B for permission, cacheable and bufferable. Set to 0, it selects set A.
- R9: Access kind `lk_acc` is read for 00, write for 01, and execute when bit 1 is 1. `lk_priv` is 1 for privileged. Permission codes: 0 privileged R; 1 privileged RX; 2 privileged RW; 3 privileged RWX; 4 both R; 5 both RX; 6 both RW; 7 both RWX; 8 privileged RW with user R; 9 privileged RWX with user RX; 10 to 15 no access. `out_viol` is 1 on a hit whose selected code denies the access.
- R10: On a hit, `out_cacheable` and `out_bufferable` are the winning region's bits from the selected set. On a miss, they are 0.
- R11: The results for an address appear on the outputs one clock cycle after that address is sampled. Back-to-back lookups produce back-to-back results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Configuration register selector |
| cfg_wdata | input | 32 | Configuration write data |
| lk_addr | input | 32 | Address under test |
| lk_acc | input | 2 | Access kind: 00 read, 01 write, 1x execute |
| lk_priv | input | 1 | 1 for a privileged access |
| out_hit | output | 1 | Address hit an enabled region |
| out_miss | output | 1 | Protection on, no region hit |
| out_viol | output | 1 | Selected permission code denies the access |
| out_region | output | 3 | Index of the winning region |
| out_cacheable | output | 1 | Cacheable attribute of the selected set |
| out_bufferable | output | 1 | Bufferable attribute of the selected set |

## Verification
The bench probes the first and last word of a 64 KB region and the first word past it. A size decode that is off by one bit moves the boundary, so one of those three results flips. It places a large region over a small one and looks up addresses inside both. A reversed priority encoder would report region 1 where region 0 is expected. It switches between subregion slices whose mask bits differ, so a design that takes its slice index from the wrong address bits picks the wrong attribute set and shows the wrong permission or cache bits. It also covers a region with a reserved size code, a region with its valid bit clear, and the whole-space size code, and it runs every lookup back to back so that an extra or missing pipeline stage shifts all results by one.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
    localparam int unsigned ADDR_W   = 32;
    localparam int unsigned NREG     = 8;
    localparam int unsigned IDX_W    = $clog2(NREG);
    localparam int unsigned NSUB     = 16;
    localparam int unsigned SUB_W    = $clog2(NSUB);
    localparam int unsigned PAGE_LSB = 12;
    localparam int unsigned BASE_W   = ADDR_W - PAGE_LSB;
    localparam int unsigned SIZE_W   = 5;
    localparam int unsigned AP_W     = 4;
    localparam int unsigned SEL_W    = 5;
    localparam int unsigned DATA_W   = 32;

    localparam logic [SIZE_W-1:0] SIZE_MIN = SIZE_W'(11);

    localparam logic [SEL_W-1:0] SEL_REGION = 5'd0;
    localparam logic [SEL_W-1:0] SEL_CTRL   = 5'd8;
    localparam logic [SEL_W-1:0] SEL_AP_A   = 5'd9;
    localparam logic [SEL_W-1:0] SEL_AP_B   = 5'd10;
    localparam logic [SEL_W-1:0] SEL_C_A    = 5'd11;
    localparam logic [SEL_W-1:0] SEL_C_B    = 5'd12;
    localparam logic [SEL_W-1:0] SEL_B_A    = 5'd13;
    localparam logic [SEL_W-1:0] SEL_B_B    = 5'd14;
    localparam logic [SEL_W-1:0] SEL_SUB    = 5'd16;

    typedef struct packed {
        logic                             en;
        logic [NREG-1:0]                  valid;
        logic [NREG-1:0][SIZE_W-1:0]      size;
        logic [NREG-1:0][BASE_W-1:0]      base;
        logic [NREG-1:0][NSUB-1:0]        smask;
        logic [NREG-1:0][AP_W-1:0]        ap_a;
        logic [NREG-1:0][AP_W-1:0]        ap_b;
        logic [NREG-1:0]                  c_a;
        logic [NREG-1:0]                  c_b;
        logic [NREG-1:0]                  b_a;
        logic [NREG-1:0]                  b_b;
    } cfg_t;

    typedef struct packed {
        logic             hit;
        logic             miss;
        logic             viol;
        logic [IDX_W-1:0] region;
        logic             cach;
        logic             bufr;
    } result_t;
endpackage

// File: rtl/mpu_cfg_regs.sv
module mpu_cfg_regs
    import mpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (sel[SEL_W-1:IDX_W] == SEL_REGION[SEL_W-1:IDX_W]) begin
                cfg_d.base[sel[IDX_W-1:0]]  = wdata[DATA_W-1:PAGE_LSB];
                cfg_d.size[sel[IDX_W-1:0]]  = wdata[SIZE_W:1];
                cfg_d.valid[sel[IDX_W-1:0]] = wdata[0];
            end else if (sel[SEL_W-1:IDX_W] == SEL_SUB[SEL_W-1:IDX_W]) begin
                cfg_d.smask[sel[IDX_W-1:0]] = wdata[NSUB-1:0];
            end else begin
                case (sel)
                    SEL_CTRL: cfg_d.en   = wdata[0];
                    SEL_AP_A: cfg_d.ap_a = wdata[AP_W*NREG-1:0];
                    SEL_AP_B: cfg_d.ap_b = wdata[AP_W*NREG-1:0];
                    SEL_C_A:  cfg_d.c_a  = wdata[NREG-1:0];
                    SEL_C_B:  cfg_d.c_b  = wdata[NREG-1:0];
                    SEL_B_A:  cfg_d.b_a  = wdata[NREG-1:0];
                    SEL_B_B:  cfg_d.b_b  = wdata[NREG-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/mpu_region_match.sv
module mpu_region_match
    import mpu_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base,
    input  logic [SIZE_W-1:0] size,
    input  logic              valid,
    input  logic [NSUB-1:0]   smask,
    output logic              hit,
    output logic              use_b
);
    logic              usable;
    logic [ADDR_W:0]   span_m1;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] start;
    logic [SUB_W-1:0]  sub_idx;

    always_comb begin
        usable   = valid && (size >= SIZE_MIN);
        span_m1  = ((ADDR_W+1)'(1) << ({1'b0, size} + 6'd1)) - (ADDR_W+1)'(1);
        low_mask = span_m1[ADDR_W-1:0];
        start    = {base, {PAGE_LSB{1'b0}}};
        hit      = usable && (((addr ^ start) & ~low_mask) == '0);
        sub_idx  = SUB_W'((addr >> (size - SIZE_W'(SUB_W - 1))) & ADDR_W'(NSUB - 1));
        use_b    = smask[sub_idx];
    end
endmodule

// File: rtl/mpu_perm_check.sv
module mpu_perm_check
    import mpu_pkg::*;
(
    input  logic [AP_W-1:0] code,
    input  logic            priv,
    input  logic [1:0]      acc,
    output logic            allowed
);
    logic pr, pw, px, ur, uw, ux;
    logic r, w, x;

    always_comb begin
        pr = 1'b0; pw = 1'b0; px = 1'b0;
        ur = 1'b0; uw = 1'b0; ux = 1'b0;
        if (!code[3]) begin
            pr = 1'b1;
            pw = code[1];
            px = code[0];
            if (code[2]) begin
                ur = 1'b1;
                uw = code[1];
                ux = code[0];
            end
        end else if (code[2:0] == 3'd0) begin
            pr = 1'b1; pw = 1'b1; ur = 1'b1;
        end else if (code[2:0] == 3'd1) begin
            pr = 1'b1; pw = 1'b1; px = 1'b1;
            ur = 1'b1; ux = 1'b1;
        end
        r = priv ? pr : ur;
        w = priv ? pw : uw;
        x = priv ? px : ux;
        allowed = acc[1] ? x : (acc[0] ? w : r);
    end
endmodule

// File: rtl/mpu_region_lookup.sv
module mpu_region_lookup
    import mpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic [31:0]       lk_addr,
    input  logic [1:0]        lk_acc,
    input  logic              lk_priv,
    output logic              out_hit,
    output logic              out_miss,
    output logic              out_viol,
    output logic [2:0]        out_region,
    output logic              out_cacheable,
    output logic              out_bufferable
);
    cfg_t             cfg_q;
    logic [NREG-1:0]  hit_vec;
    logic [NREG-1:0]  useb_vec;
    logic             any_hit;
    logic [IDX_W-1:0] win;
    logic             win_b;
    logic [AP_W-1:0]  win_code;
    logic             win_c;
    logic             win_bf;
    logic             allowed;
    logic             prot_en;
    result_t          res_d, res_q;

    mpu_cfg_regs u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_region
        mpu_region_match u_match (
            .addr  (lk_addr),
            .base  (cfg_q.base[g]),
            .size  (cfg_q.size[g]),
            .valid (cfg_q.valid[g]),
            .smask (cfg_q.smask[g]),
            .hit   (hit_vec[g]),
            .use_b (useb_vec[g])
        );
    end

    // lowest index wins: scan from the top so lower indices overwrite
    always_comb begin
        any_hit = 1'b0;
        win     = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win     = IDX_W'(i);
            end
        end
        win_b    = useb_vec[win];
        win_code = win_b ? cfg_q.ap_b[win] : cfg_q.ap_a[win];
        win_c    = win_b ? cfg_q.c_b[win]  : cfg_q.c_a[win];
        win_bf   = win_b ? cfg_q.b_b[win]  : cfg_q.b_a[win];
    end

    mpu_perm_check u_perm (
        .code    (win_code),
        .priv    (lk_priv),
        .acc     (lk_acc),
        .allowed (allowed)
    );

    always_comb begin
        res_d = '0;
        if (cfg_q.en) begin
            if (any_hit) begin
                res_d.hit    = 1'b1;
                res_d.region = win;
                res_d.viol   = !allowed;
                res_d.cach   = win_c;
                res_d.bufr   = win_bf;
            end else begin
                res_d.miss   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign prot_en        = cfg_q.en;
    assign out_hit        = res_q.hit;
    assign out_miss       = res_q.miss;
    assign out_viol       = res_q.viol;
    assign out_region     = res_q.region;
    assign out_cacheable  = res_q.cach;
    assign out_bufferable = res_q.bufr;
endmodule

// File: rtl/mpu_region_lookup_chk.sv
module mpu_region_lookup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       hit,
    input logic       miss,
    input logic       viol,
    input logic [2:0] region,
    input logic       cach,
    input logic       bufr
);
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (!hit && !miss && !viol && !cach && !bufr && region == 3'd0));

    p_hit_or_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) |-> (hit != miss));

    p_viol_on_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> hit);

    p_no_attr_off_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (!cach && !bufr && region == 3'd0));
endmodule

bind mpu_region_lookup mpu_region_lookup_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (prot_en),
    .hit    (out_hit),
    .miss   (out_miss),
    .viol   (out_viol),
    .region (out_region),
    .cach   (out_cacheable),
    .bufr   (out_bufferable)
);

// File: tb/mpu_region_lookup_tb.sv
module mpu_region_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] lk_addr = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_priv = 1'b0;
    logic        out_hit, out_miss, out_viol, out_cacheable, out_bufferable;
    logic [2:0]  out_region;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    mpu_region_lookup u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .lk_addr(lk_addr), .lk_acc(lk_acc),
        .lk_priv(lk_priv), .out_hit(out_hit), .out_miss(out_miss),
        .out_viol(out_viol), .out_region(out_region),
        .out_cacheable(out_cacheable), .out_bufferable(out_bufferable)
    );

    typedef struct {
        bit hit; bit miss; bit viol; int region; bit c; bit b; string tag;
    } exp_t;
    exp_t exp_q[$];

    // shadow configuration
    bit        sh_en;
    bit [31:0] sh_word [8];
    bit [15:0] sh_mask [8];
    bit [31:0] sh_ap_a, sh_ap_b;
    bit [7:0]  sh_ca, sh_cb, sh_ba, sh_bb;

    // {ux,uw,ur,px,pw,pr} per permission code (R9)
    function automatic bit [5:0] perm_bits(int code);
        case (code)
            0: return 6'b000_001;
            1: return 6'b000_101;
            2: return 6'b000_011;
            3: return 6'b000_111;
            4: return 6'b001_001;
            5: return 6'b101_101;
            6: return 6'b011_011;
            7: return 6'b111_111;
            8: return 6'b001_011;
            9: return 6'b101_111;
            default: return 6'b000_000;
        endcase
    endfunction

    function automatic exp_t model(bit [31:0] a, bit [1:0] acc, bit priv, string tag);
        exp_t e;
        e.hit = 0; e.miss = 0; e.viol = 0; e.region = 0; e.c = 0; e.b = 0; e.tag = tag;
        if (!sh_en) return e;
        for (int i = 0; i < 8; i++) begin
            int sz = int'(sh_word[i][5:1]);
            if (sh_word[i][0] && sz >= 11) begin
                longint unsigned span = 64'd1 << (sz + 1);
                longint unsigned st   = {32'd0, sh_word[i][31:12], 12'd0};
                longint unsigned aa   = {32'd0, a};
                if (aa / span == st / span) begin
                    int sub = int'((aa % span) / (span / 16));
                    bit useb = sh_mask[i][sub];
                    int code = useb ? int'((sh_ap_b >> (4*i)) & 15) : int'((sh_ap_a >> (4*i)) & 15);
                    bit [5:0] pb = perm_bits(code);
                    bit [2:0] rights = priv ? pb[2:0] : pb[5:3];
                    bit ok = acc[1] ? rights[2] : (acc[0] ? rights[1] : rights[0]);
                    e.hit = 1; e.region = i; e.viol = !ok;
                    e.c = useb ? sh_cb[i] : sh_ca[i];
                    e.b = useb ? sh_bb[i] : sh_ba[i];
                    return e;
                end
            end
        end
        e.miss = 1;
        return e;
    endfunction

    task automatic cfg_write(bit [4:0] sel, bit [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        if (sel < 8) sh_word[sel] = {data[31:12], 6'd0, data[5:0]};
        else if (sel >= 16 && sel < 24) sh_mask[sel-16] = data[15:0];
        else case (sel)
            8:  sh_en   = data[0];
            9:  sh_ap_a = data;
            10: sh_ap_b = data;
            11: sh_ca   = data[7:0];
            12: sh_cb   = data[7:0];
            13: sh_ba   = data[7:0];
            14: sh_bb   = data[7:0];
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_region(int n, bit [31:0] base, int size, bit v);
        cfg_write(5'(n), {base[31:12], 6'd0, 5'(size), v});
    endtask

    task automatic lookup(bit [31:0] a, bit [1:0] acc, bit priv, string tag);
        exp_t e;
        e = model(a, acc, priv, tag);
        @(negedge clk);
        lk_addr = a; lk_acc = acc; lk_priv = priv;
        @(posedge clk);
        #1 exp_q.push_back(e);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (out_hit !== e.hit || out_miss !== e.miss || out_viol !== e.viol ||
                int'(out_region) != e.region || out_cacheable !== e.c || out_bufferable !== e.b) begin
                errors++;
                $display("FAIL %s: got hit=%0d miss=%0d viol=%0d reg=%0d c=%0d b=%0d exp hit=%0d miss=%0d viol=%0d reg=%0d c=%0d b=%0d",
                    e.tag, out_hit, out_miss, out_viol, out_region, out_cacheable, out_bufferable,
                    e.hit, e.miss, e.viol, e.region, e.c, e.b);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin sh_word[i] = '0; sh_mask[i] = '0; end
        sh_en = 0; sh_ap_a = '0; sh_ap_b = '0; sh_ca = '0; sh_cb = '0; sh_ba = '0; sh_bb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if ({out_hit, out_miss, out_viol, out_region, out_cacheable, out_bufferable} !== 8'd0) begin
            errors++;
            $display("FAIL R1 reset outputs: got %b expected 0",
                {out_hit, out_miss, out_viol, out_region, out_cacheable, out_bufferable});
        end
        lookup(32'h1000_0100, 2'b00, 1'b0, "R1 disabled after reset");

        // R2: load configuration through the write port while disabled
        set_region(0, 32'h1000_0000, 15, 1'b1);
        cfg_write(5'd9,  32'h0000_0057);
        cfg_write(5'd10, 32'h0000_0080);
        cfg_write(5'd16, 32'h0000_0002);
        cfg_write(5'd11, 32'h0000_0001);
        cfg_write(5'd14, 32'h0000_0001);
        lookup(32'h1000_0100, 2'b01, 1'b0, "R3 disabled ignores region");

        cfg_write(5'd8, 32'h1);
        // R5 R8 R10 R11 back to back
        lookup(32'h1000_0100, 2'b00, 1'b0, "R8 set A user read R11");
        lookup(32'h1000_1000, 2'b00, 1'b0, "R8 set B user read R11");
        lookup(32'h1000_1004, 2'b00, 1'b1, "R9 code0 priv read");
        lookup(32'h1000_1008, 2'b01, 1'b1, "R9 code0 priv write");
        lookup(32'h1000_100C, 2'b10, 1'b1, "R9 code0 priv exec");
        lookup(32'h1000_FFFC, 2'b01, 1'b0, "R5 last word R10");
        lookup(32'h1001_0000, 2'b00, 1'b0, "R7 one past end");
        lookup(32'h0FFF_FFFC, 2'b00, 1'b1, "R7 below start");

        // R6 overlap with larger region 1
        set_region(1, 32'h1000_0000, 20, 1'b1);
        cfg_write(5'd17, 32'h0000_8000);
        lookup(32'h1000_0200, 2'b00, 1'b0, "R6 lower index wins");
        lookup(32'h1001_0000, 2'b10, 1'b0, "R9 code5 user exec");
        lookup(32'h1001_0004, 2'b01, 1'b0, "R9 code5 user write");
        lookup(32'h101F_0000, 2'b01, 1'b0, "R8 region1 sub15 code8 user write");
        lookup(32'h101F_0004, 2'b00, 1'b0, "R8 region1 sub15 code8 user read");
        lookup(32'h101F_0008, 2'b01, 1'b1, "R9 code8 priv write");

        // R4 invalid regions
        set_region(2, 32'h2000_0000, 10, 1'b1);
        set_region(3, 32'h3000_0000, 12, 1'b0);
        lookup(32'h2000_0000, 2'b00, 1'b1, "R4 reserved size");
        lookup(32'h3000_0010, 2'b00, 1'b1, "R4 valid clear");
        set_region(3, 32'h3000_0000, 12, 1'b1);
        lookup(32'h3000_0010, 2'b00, 1'b0, "R4 valid set");
        lookup(32'h3000_2000, 2'b00, 1'b0, "R5 past 8KB region");

        // R5 whole space region
        set_region(7, 32'h0000_0000, 31, 1'b1);
        lookup(32'h7FFF_0000, 2'b00, 1'b1, "R5 size 31 covers all");
        lookup(32'hFFFF_FFFC, 2'b00, 1'b1, "R5 size 31 top");
        lookup(32'h1000_0000, 2'b00, 1'b0, "R6 region0 beats region7");

        // R3 disable again
        cfg_write(5'd8, 32'h0);
        lookup(32'h1000_0000, 2'b00, 1'b0, "R3 disabled again");
        lookup(32'h5000_0000, 2'b01, 1'b0, "R3 disabled no miss");

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule